// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous client and an external asynchronous static RAM of 32,768 sixteen-bit words. The client posts a single request with a strobe. The request carries a write flag, a word address, write data and a two-bit lane mask. The controller then plays out the active-low chip, write, output and byte-lane enables and the shared tristate data bus. The length of each phase is held for a whole number of clock cycles, chosen so that the memory's minimum timings hold at the configured clock period.

Each phase length is taken from a nanosecond-style requirement given in picoseconds. It is rounded up to whole cycles of `CLK_PS`, and never drops below one cycle. With the default 8 ns clock, a read holds the bus for 2 cycles, a write pulse lasts 1 cycle, and a read is followed by 1 turnaround cycle. Read data comes back with a one-cycle valid pulse, and a ready flag shows when a new request may be posted.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset, chip, write and output enables and both byte-lane enables are high. The data bus is not driven, ready is high, read-valid is low and read data is zero.
- R2: A read accepted on edge E (reqValid and ready both high) raises rdValid for exactly one cycle after edge E+RD_CYC. RD_CYC is ceil(ACCESS_PS/CLK_PS) with a minimum of 1, which is 2 by default.
- R3: While a read runs, chip and output enables are low and write enable is high. The lower-lane enable is low only if mask bit 0 is set, and the upper-lane enable is low only if mask bit 1 is set (mask bit 0 covers data bits 7..0, bit 1 covers bits 15..8, 1 = enabled). In the returned word, enabled lanes hold the memory contents and disabled lanes read as zero.
- R4: A write accepted on edge E holds write enable low for WP_CYC cycles, where WP_CYC is ceil(WPULSE_PS/CLK_PS) with a minimum of 1. During the pulse, chip enable is low and output enable is high. Write enable then rises with chip enable still low for one more cycle, and ready returns after edge E+WP_CYC+1.
- R5: A write changes only the lanes enabled in its mask. A mask of zero leaves the word unchanged.
- R6: The controller drives the data bus with the write data during the write pulse and the following write-end cycle. It drives nothing at any other time, and never while output enable is low.
- R7: The address stays stable for as long as chip enable stays low.
- R8: After each read, chip, output and write enables stay high for TURN_CYC cycles before any further access. TURN_CYC is ceil(TURN_PS/CLK_PS) with a minimum of 1.
- R9: Ready falls on the cycle after a request is accepted and stays low until the controller is idle again. A request posted while ready is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, taken when ready is high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 15 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane mask, bit 0 = bits 7..0, bit 1 = bits 15..8 |
| rdData | output | 16 | Read data, disabled lanes zero |
| rdValid | output | 1 | One-cycle pulse with read data |
| ready | output | 1 | Controller idle, request may be posted |
| sramCeN | output | 1 | Chip enable, active low |
| sramWeN | output | 1 | Write enable, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramLbN | output | 1 | Lower lane enable, active low |
| sramUbN | output | 1 | Upper lane enable, active low |
| sramAddr | output | 15 | Memory address |
| sramDq | inout | 16 | Bidirectional data bus |

## Verification
Every result has a fixed due cycle counted from the accepting edge. The read word and its valid pulse are due after edge E+RD_CYC, and turnaround ends with ready after edge E+RD_CYC+TURN_CYC. The write strobe is low through edge E+WP_CYC, and ready is back after edge E+WP_CYC+1. The bench walks the clock edge by edge from the accepting edge and samples on the falling edge of the exact cycle in which each pin or flag is due. The due cycle comes from its own copy of the rounding rule, so a phase that runs one cycle early or late is caught at that cycle. Memory contents are checked by later read-back against a shadow copy that is updated per lane.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WPULSE,
    ST_WEND
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic chipSel;
    logic outEn;
    logic wrPulse;
    logic laneSel;
    logic busDrive;
    logic capture;
  } ctrlStrobe_t;

  // round a time requirement up to whole clock cycles, never below one
  function automatic int cyclesFor(input int needPs, input int clkPs);
    int c;
    c = (needPs + clkPs - 1) / clkPs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 2,
  parameter int WP_CYC   = 1,
  parameter int TURN_CYC = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        ready,
  output ctrlStrobe_t strobe
);

  localparam int MAX_A   = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int MAX_CYC = (MAX_A > TURN_CYC) ? MAX_A : TURN_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctrlState_t state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          if (reqWrite) begin
            stateNext = ST_WPULSE;
            cntNext   = CNT_W'(WP_CYC - 1);
          end else begin
            stateNext = ST_READ;
            cntNext   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_READ: begin
        strobe.chipSel = 1'b1;
        strobe.outEn   = 1'b1;
        strobe.laneSel = 1'b1;
        if (cnt == '0) begin
          strobe.capture = 1'b1;
          stateNext      = ST_TURN;
          cntNext        = CNT_W'(TURN_CYC - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_TURN: begin
        if (cnt == '0) stateNext = ST_IDLE;
        else           cntNext   = cnt - 1'b1;
      end
      ST_WPULSE: begin
        strobe.chipSel  = 1'b1;
        strobe.wrPulse  = 1'b1;
        strobe.laneSel  = 1'b1;
        strobe.busDrive = 1'b1;
        if (cnt == '0) stateNext = ST_WEND;
        else           cntNext   = cnt - 1'b1;
      end
      ST_WEND: begin
        strobe.chipSel  = 1'b1;
        strobe.laneSel  = 1'b1;
        strobe.busDrive = 1'b1;
        stateNext       = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign ready = (state == ST_IDLE);

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [1:0]        laneN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      maskQ  <= '0;
    end else if (strobe.latchReq) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      maskQ  <= reqMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= strobe.capture;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneN[g] = ~(strobe.laneSel & maskQ[g]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rdData[g*LANE_W +: LANE_W] <= '0;
      else if (strobe.capture)
        rdData[g*LANE_W +: LANE_W] <= maskQ[g] ? dqIn[g*LANE_W +: LANE_W] : '0;
    end
  end

  assign sramAddr = addrQ;
  assign sramCeN  = ~strobe.chipSel;
  assign sramOeN  = ~strobe.outEn;
  assign sramWeN  = ~strobe.wrPulse;
  assign dqOut    = wdataQ;
  assign dqOe     = strobe.busDrive;

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 16,
  parameter int CLK_PS    = 8000,
  parameter int ACCESS_PS = 10000,
  parameter int WPULSE_PS = 7000,
  parameter int TURN_PS   = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              ready,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic              sramLbN,
  output logic              sramUbN,
  output logic [ADDR_W-1:0] sramAddr,
  inout  wire  [DATA_W-1:0] sramDq
);

  localparam int RD_CYC   = cyclesFor(ACCESS_PS, CLK_PS);
  localparam int WP_CYC   = cyclesFor(WPULSE_PS, CLK_PS);
  localparam int TURN_CYC = cyclesFor(TURN_PS, CLK_PS);

  ctrlStrobe_t       strobe;
  logic [DATA_W-1:0] dqOut;
  logic              dqOe;
  logic [1:0]        laneN;

  sram_ctrl_fsm #(
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .ready   (ready),
    .strobe  (strobe)
  );

  sram_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .dqIn    (sramDq),
    .dqOut   (dqOut),
    .dqOe    (dqOe),
    .sramAddr(sramAddr),
    .sramCeN (sramCeN),
    .sramWeN (sramWeN),
    .sramOeN (sramOeN),
    .laneN   (laneN),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

  assign sramLbN = laneN[0];
  assign sramUbN = laneN[1];
  assign sramDq  = dqOe ? dqOut : 'z;

endmodule

// File: rtl/async_sram_ctrl_chk.sv
module async_sram_ctrl_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              ready,
  input logic              rdValid,
  input logic              sramCeN,
  input logic              sramWeN,
  input logic              sramOeN,
  input logic [ADDR_W-1:0] sramAddr,
  input logic              dqOe
);

  // R1: an idle controller leaves the memory deselected
  p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (sramCeN && sramWeN && sramOeN));

  // R2: read-valid lasts a single cycle
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R4: write strobe only with chip selected and outputs off
  p_we_oe_r4: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> (sramOeN && !sramCeN));

  // R6: bus driven only while the memory outputs are off
  p_drive_oe_r6: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> sramOeN);

  // R7: address held while chip enable stays low
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN)) |-> $stable(sramAddr));

  // R8: end of a read is followed by a deselected, busy cycle
  p_turn_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramOeN) |-> (sramCeN && !ready));

  // R9: accepted request makes the controller busy
  p_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ready) |=> !ready);

endmodule

bind async_sram_ctrl async_sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .ready   (ready),
  .rdValid (rdValid),
  .sramCeN (sramCeN),
  .sramWeN (sramWeN),
  .sramOeN (sramOeN),
  .sramAddr(sramAddr),
  .dqOe    (dqOe)
);

// File: tb/async_sram_ctrl_bench.sv
`timescale 1ns/1ps
module async_sram_ctrl_bench;

  localparam int CLK_PS = 8000;

  function automatic int cyc(input int needPs);
    int c;
    c = (needPs + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RD_CYC   = cyc(10000);
  localparam int WP_CYC   = cyc(7000);
  localparam int TURN_CYC = cyc(5000);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic [15:0] rdData;
  logic        rdValid, ready;
  logic        sramCeN, sramWeN, sramOeN, sramLbN, sramUbN;
  logic [14:0] sramAddr;
  wire  [15:0] sramDq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  async_sram_ctrl u_async_sram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rdData(rdData), .rdValid(rdValid), .ready(ready),
    .sramCeN(sramCeN), .sramWeN(sramWeN), .sramOeN(sramOeN),
    .sramLbN(sramLbN), .sramUbN(sramUbN), .sramAddr(sramAddr), .sramDq(sramDq)
  );

  // ---------------- memory model ----------------
  logic [15:0] mem [int];
  logic [15:0] shadow [int];
  logic [15:0] memWord = '0;

  always @(negedge clk)
    memWord <= mem.exists(int'(sramAddr)) ? mem[int'(sramAddr)] : 16'h0;

  wire memRd = !sramCeN && !sramOeN && sramWeN;
  assign sramDq[7:0]  = (memRd && !sramLbN) ? memWord[7:0]  : 8'hzz;
  assign sramDq[15:8] = (memRd && !sramUbN) ? memWord[15:8] : 8'hzz;

  always @(posedge sramWeN) begin
    if (rstN && !sramCeN) begin
      logic [15:0] w;
      w = mem.exists(int'(sramAddr)) ? mem[int'(sramAddr)] : 16'h0;
      if (!sramLbN) w[7:0]  = sramDq[7:0];
      if (!sramUbN) w[15:8] = sramDq[15:8];
      mem[int'(sramAddr)] = w;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] expRead(input logic [14:0] a, input logic [1:0] m);
    logic [15:0] w;
    w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
    if (!m[0]) w[7:0]  = 8'h0;
    if (!m[1]) w[15:8] = 8'h0;
    return w;
  endfunction

  function automatic logic [4:0] pins(input logic ce, input logic oe, input logic we,
                                      input logic lb, input logic ub);
    return {ce, oe, we, lb, ub};
  endfunction

  function automatic logic [4:0] curPins();
    return {sramCeN, sramOeN, sramWeN, sramLbN, sramUbN};
  endfunction

  task automatic waitReady();
    while (!ready) @(negedge clk);
  endtask

  // read; optionally post a spurious write while busy (R9)
  task automatic doRead(input logic [14:0] a, input logic [1:0] m, input bit junk,
                        input logic [14:0] junkAddr);
    waitReady();
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; reqMask = m;
    reqWdata = 16'($urandom);
    @(posedge clk);
    for (int i = 1; i <= RD_CYC; i++) begin
      @(negedge clk);
      if (i == 1) begin
        if (junk) begin
          reqWrite = 1'b1; reqAddr = junkAddr; reqMask = 2'b11; reqWdata = 16'hDEAD;
        end else reqValid = 1'b0;
      end
      chk("R3 read pins", 32'(curPins()), 32'(pins(1'b0, 1'b0, 1'b1, ~m[0], ~m[1])));
      chk("R7 read addr", 32'(sramAddr), 32'(a));
      chk("R2 no early valid", 32'(rdValid), 32'd0);
      chk("R9 busy", 32'(ready), 32'd0);
      @(posedge clk);
    end
    @(negedge clk);
    reqValid = 1'b0;
    chk("R2 valid due", 32'(rdValid), 32'd1);
    chk("R3 read data", 32'(rdData), 32'(expRead(a, m)));
    chk("R8 turn pins", 32'(curPins()), 32'h1F);
    chk("R9 busy in turn", 32'(ready), 32'd0);
    for (int t = 1; t <= TURN_CYC; t++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R2 single pulse", 32'(rdValid), 32'd0);
      chk("R8 ready after turn", 32'(ready), 32'(t == TURN_CYC));
    end
  endtask

  task automatic doWrite(input logic [14:0] a, input logic [15:0] d, input logic [1:0] m);
    waitReady();
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqMask = m; reqWdata = d;
    @(posedge clk);
    for (int i = 1; i <= WP_CYC; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
      chk("R4 pulse pins", 32'(curPins()), 32'(pins(1'b0, 1'b1, 1'b0, ~m[0], ~m[1])));
      chk("R6 bus data", 32'(sramDq), 32'(d));
      chk("R7 write addr", 32'(sramAddr), 32'(a));
      @(posedge clk);
    end
    @(negedge clk);
    chk("R4 write end pins", 32'(curPins()), 32'(pins(1'b0, 1'b1, 1'b1, ~m[0], ~m[1])));
    chk("R4 busy at end", 32'(ready), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R4 ready back", 32'(ready), 32'd1);
    chk("R4 deselected", 32'(sramCeN), 32'd1);
    begin
      logic [15:0] w;
      w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
      if (m[0]) w[7:0]  = d[7:0];
      if (m[1]) w[15:8] = d[15:8];
      shadow[int'(a)] = w;
    end
  endtask

  function automatic logic [14:0] poolAddr(input int k);
    return 15'((k * 2053 + 7) & 32'h7FFF);
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset pins", 32'(curPins()), 32'h1F);
    chk("R1 reset ready", 32'(ready), 32'd1);
    chk("R1 reset valid", 32'(rdValid), 32'd0);
    chk("R1 reset data", 32'(rdData), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle pins", 32'(curPins()), 32'h1F);

    // directed
    doWrite(15'h0000, 16'h1234, 2'b11);
    doWrite(15'h7FFF, 16'hA5C3, 2'b11);
    doRead (15'h0000, 2'b11, 0, '0);
    doRead (15'h7FFF, 2'b11, 0, '0);
    doWrite(15'h0000, 16'hFF00, 2'b01);   // R5 lower lane only
    doRead (15'h0000, 2'b11, 0, '0);
    doWrite(15'h0000, 16'h00EE, 2'b10);   // R5 upper lane only
    doRead (15'h0000, 2'b11, 0, '0);
    doWrite(15'h7FFF, 16'h0000, 2'b00);   // R5 nothing written
    doRead (15'h7FFF, 2'b11, 0, '0);
    doRead (15'h7FFF, 2'b01, 0, '0);      // R3 lane masking
    doRead (15'h7FFF, 2'b10, 0, '0);
    doRead (15'h7FFF, 2'b00, 0, '0);
    doRead (15'h1111, 2'b11, 1, 15'h0123); // R9 junk ignored
    doRead (15'h0123, 2'b11, 0, '0);
    chk("R9 no stray valid", 32'(rdValid), 32'd0);

    // random
    for (int n = 0; n < 300; n++) begin
      logic [14:0] a;
      logic [1:0]  m;
      a = poolAddr(int'($urandom_range(0, 15)));
      m = 2'($urandom);
      if ($urandom_range(0, 1) == 1) doWrite(a, 16'($urandom), m);
      else doRead(a, m, ($urandom_range(0, 3) == 0), poolAddr(int'($urandom_range(0, 15))));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule